// File: doc/BRIEF.md
# Cycle-Counted Interrupt Hold Timer

This block suppresses interrupt delivery for a programmed number of instruction cycles. A hold command carries a count N. The command cycle itself is masked. The counter then holds N and counts down once per instruction cycle, which gives N+1 masked cycles in total. While the counter is non-zero, no request reaches the interrupt output. Software can read the counter at any time and can overwrite it. This lets code save the count, force it to a long hold and restore it afterwards.

The main hazard is a re-arm that lands on the cycle where the count runs out. A new command accepted in that cycle reloads the counter, and masking continues without any gap. Instruction cycles are marked by a strobe. On cycles without the strobe, nothing changes state.

Top module: `irq_hold_timer`

## Requirements
- R1: After reset, the count is 0, the hold flag is low, and requests are not masked.
- R2: A command is accepted when `cmd_valid` and `cyc_en` are both high. `irq_out` is low during that cycle. From the next cycle, the count equals the command operand.
- R3: On each strobed cycle with no command and no write, a non-zero count drops by one. `irq_out` stays low while the count is non-zero, so operand N masks N+1 instruction cycles.
- R4: On cycles where `cyc_en` is low, the count and the hold flag keep their values, and a command or write presented on such a cycle has no effect.
- R5: A command accepted while the count is above one reloads the count with the new operand. Masking continues without a gap.
- R6: A command accepted in the cycle where the count is one, or in the first cycle where it reads zero, reloads the counter. `irq_out` stays low through that cycle and the following ones.
- R7: A strobed write with `cnt_wr_en` loads `cnt_wr_data` into the count. The hold flag is high exactly when the count is non-zero.
- R8: If a command and a write are accepted in the same cycle, the command operand is loaded and the write data is discarded.
- R9: When the count is zero and no command is being accepted, `irq_out` equals `irq_gie` AND the OR of all `irq_req` bits, in the same cycle.
- R10: The largest operand, 0x3FFF, loads in full and counts down from that value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cyc_en | input | 1 | Instruction-cycle strobe |
| cmd_valid | input | 1 | Hold command request |
| cmd_count | input | CNT_W (14) | Hold command operand N |
| cnt_wr_en | input | 1 | Direct write of the count |
| cnt_wr_data | input | CNT_W (14) | Value for a direct write |
| irq_req | input | NUM_IRQ (8) | Pending interrupt requests |
| irq_gie | input | 1 | Global interrupt enable |
| irq_out | output | 1 | Interrupt request after masking |
| hold_active | output | 1 | Hold in progress |
| hold_count | output | CNT_W (14) | Current count, readable by software |

## Verification
A corrupted count shows at `hold_count` on the very next cycle. It also changes how many cycles `irq_out` stays low. A hold flag that disagrees with the count either lets a request through while the count is non-zero, or blocks one after expiry, in the same cycle as the error. The bench models the expected count and output cycle by cycle. It therefore catches a wrong value at the first cycle where it appears, including a one-cycle leak around the re-arm point.

// File: rtl/irq_hold_pkg.sv
package irq_hold_pkg;

    localparam int unsigned HOLD_CNT_W_DFLT = 14;
    localparam int unsigned HOLD_IRQ_N_DFLT = 8;

    // Source that updates the counter in a given cycle
    typedef enum logic [1:0] {
        SRC_KEEP  = 2'd0,
        SRC_CMD   = 2'd1,
        SRC_WRITE = 2'd2,
        SRC_TICK  = 2'd3
    } load_src_e;

endpackage

// File: rtl/irq_hold_select.sv
module irq_hold_select
    import irq_hold_pkg::*;
(
    input  logic      cyc_en,
    input  logic      cmd_valid,
    input  logic      cnt_wr_en,
    input  logic      cnt_nonzero,
    output load_src_e src,
    output logic      cmd_fire
);

    always_comb begin
        cmd_fire = cyc_en & cmd_valid;
        if (!cyc_en) begin
            src = SRC_KEEP;
        end else if (cmd_valid) begin
            src = SRC_CMD;            // command outranks a write
        end else if (cnt_wr_en) begin
            src = SRC_WRITE;
        end else if (cnt_nonzero) begin
            src = SRC_TICK;
        end else begin
            src = SRC_KEEP;
        end
    end

endmodule

// File: rtl/irq_hold_counter.sv
module irq_hold_counter
    import irq_hold_pkg::*;
#(
    parameter int unsigned CNT_W = HOLD_CNT_W_DFLT
) (
    input  logic             clk,
    input  logic             rst_n,
    input  load_src_e        src,
    input  logic [CNT_W-1:0] cmd_count,
    input  logic [CNT_W-1:0] wr_data,
    output logic [CNT_W-1:0] cnt,
    output logic             active
);

    localparam logic [CNT_W-1:0] CNT_ONE  = CNT_W'(1);
    localparam logic [CNT_W-1:0] CNT_ZERO = '0;

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
        logic             active;
    } state_t;

    state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        unique case (src)
            SRC_CMD: begin
                st_d.cnt    = cmd_count;
                st_d.active = (cmd_count != CNT_ZERO);
            end
            SRC_WRITE: begin
                st_d.cnt    = wr_data;
                st_d.active = (wr_data != CNT_ZERO);
            end
            SRC_TICK: begin
                st_d.cnt    = st_q.cnt - CNT_ONE;
                st_d.active = (st_q.cnt != CNT_ONE);
            end
            default: begin
                st_d = st_q;
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign cnt    = st_q.cnt;
    assign active = st_q.active;

endmodule

// File: rtl/irq_hold_gate.sv
module irq_hold_gate #(
    parameter int unsigned NUM_IRQ = 8
) (
    input  logic [NUM_IRQ-1:0] irq_req,
    input  logic               irq_gie,
    input  logic               hold_active,
    input  logic               cmd_fire,
    output logic               irq_out
);

    logic [NUM_IRQ:0] any_chain;

    assign any_chain[0] = 1'b0;

    generate
        for (genvar i = 0; i < NUM_IRQ; i++) begin : g_or
            assign any_chain[i+1] = any_chain[i] | irq_req[i];
        end
    endgenerate

    // The command cycle is masked even before the counter is loaded
    assign irq_out = irq_gie & any_chain[NUM_IRQ] & ~(hold_active | cmd_fire);

endmodule

// File: rtl/irq_hold_timer.sv
module irq_hold_timer
    import irq_hold_pkg::*;
#(
    parameter int unsigned CNT_W   = HOLD_CNT_W_DFLT,
    parameter int unsigned NUM_IRQ = HOLD_IRQ_N_DFLT
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               cyc_en,
    input  logic               cmd_valid,
    input  logic [CNT_W-1:0]   cmd_count,
    input  logic               cnt_wr_en,
    input  logic [CNT_W-1:0]   cnt_wr_data,
    input  logic [NUM_IRQ-1:0] irq_req,
    input  logic               irq_gie,
    output logic               irq_out,
    output logic               hold_active,
    output logic [CNT_W-1:0]   hold_count
);

    load_src_e        src;
    logic             cmd_fire;
    logic             cnt_nonzero;
    logic [CNT_W-1:0] cnt;
    logic             active;

    assign cnt_nonzero = (cnt != '0);

    irq_hold_select u_sel (
        .cyc_en     (cyc_en),
        .cmd_valid  (cmd_valid),
        .cnt_wr_en  (cnt_wr_en),
        .cnt_nonzero(cnt_nonzero),
        .src        (src),
        .cmd_fire   (cmd_fire)
    );

    irq_hold_counter #(.CNT_W(CNT_W)) u_cnt (
        .clk      (clk),
        .rst_n    (rst_n),
        .src      (src),
        .cmd_count(cmd_count),
        .wr_data  (cnt_wr_data),
        .cnt      (cnt),
        .active   (active)
    );

    irq_hold_gate #(.NUM_IRQ(NUM_IRQ)) u_gate (
        .irq_req    (irq_req),
        .irq_gie    (irq_gie),
        .hold_active(active),
        .cmd_fire   (cmd_fire),
        .irq_out    (irq_out)
    );

    assign hold_active = active;
    assign hold_count  = cnt;

endmodule

// File: rtl/irq_hold_timer_chk.sv
module irq_hold_timer_chk #(
    parameter int unsigned CNT_W   = 14,
    parameter int unsigned NUM_IRQ = 8
) (
    input logic               clk,
    input logic               rst_n,
    input logic               cyc_en,
    input logic               cmd_valid,
    input logic [CNT_W-1:0]   cmd_count,
    input logic               cnt_wr_en,
    input logic [CNT_W-1:0]   cnt_wr_data,
    input logic [NUM_IRQ-1:0] irq_req,
    input logic               irq_gie,
    input logic               irq_out,
    input logic               hold_active,
    input logic [CNT_W-1:0]   hold_count
);

    assert_mask_while_counting_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (hold_count != '0) |-> !irq_out);

    assert_flag_tracks_count_R7: assert property (@(posedge clk) disable iff (!rst_n)
        hold_active == (hold_count != '0));

    assert_cmd_cycle_masked_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (cyc_en && cmd_valid) |-> !irq_out);

    assert_cmd_loads_operand_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (cyc_en && cmd_valid) |=> hold_count == $past(cmd_count));

    assert_idle_holds_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !cyc_en |=> $stable(hold_count) && $stable(hold_active));

    assert_tick_decrement_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (cyc_en && !cmd_valid && !cnt_wr_en && hold_count != '0)
        |=> hold_count == CNT_W'($past(hold_count) - 1'b1));

    assert_write_loads_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (cyc_en && !cmd_valid && cnt_wr_en) |=> hold_count == $past(cnt_wr_data));

    assert_pass_when_clear_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (hold_count == '0 && !(cyc_en && cmd_valid)) |-> irq_out == (irq_gie && (|irq_req)));

endmodule

bind irq_hold_timer irq_hold_timer_chk #(.CNT_W(CNT_W), .NUM_IRQ(NUM_IRQ)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .cyc_en     (cyc_en),
    .cmd_valid  (cmd_valid),
    .cmd_count  (cmd_count),
    .cnt_wr_en  (cnt_wr_en),
    .cnt_wr_data(cnt_wr_data),
    .irq_req    (irq_req),
    .irq_gie    (irq_gie),
    .irq_out    (irq_out),
    .hold_active(hold_active),
    .hold_count (hold_count)
);

// File: tb/irq_hold_timer_tb.sv
module irq_hold_timer_tb;

    localparam int CNT_W   = 14;
    localparam int NUM_IRQ = 8;

    typedef struct {
        logic             irq;
        logic             act;
        logic [CNT_W-1:0] cnt;
        string            tag;
    } item_t;

    logic               clk = 1'b0;
    logic               rst_n = 1'b0;
    logic               cyc_en = 1'b0;
    logic               cmd_valid = 1'b0;
    logic [CNT_W-1:0]   cmd_count = '0;
    logic               cnt_wr_en = 1'b0;
    logic [CNT_W-1:0]   cnt_wr_data = '0;
    logic [NUM_IRQ-1:0] irq_req = '0;
    logic               irq_gie = 1'b0;
    logic               irq_out;
    logic               hold_active;
    logic [CNT_W-1:0]   hold_count;

    item_t     exp_q[$];
    int        n_checks = 0;
    int        n_fail   = 0;
    bit        done     = 1'b0;
    int        m_cnt    = 0;   // reference count

    always #10 clk = ~clk;     // 50 MHz

    irq_hold_timer #(.CNT_W(CNT_W), .NUM_IRQ(NUM_IRQ)) u_dut (
        .clk(clk), .rst_n(rst_n), .cyc_en(cyc_en), .cmd_valid(cmd_valid),
        .cmd_count(cmd_count), .cnt_wr_en(cnt_wr_en), .cnt_wr_data(cnt_wr_data),
        .irq_req(irq_req), .irq_gie(irq_gie), .irq_out(irq_out),
        .hold_active(hold_active), .hold_count(hold_count)
    );

    // Driver: apply one cycle of stimulus and push the expected outputs
    task automatic step(input logic cy, input logic cm, input int n,
                        input logic we, input int wd,
                        input logic [NUM_IRQ-1:0] rq, input logic ge,
                        input string tag);
        item_t it;
        logic  fire;
        @(negedge clk);
        cyc_en = cy; cmd_valid = cm; cmd_count = CNT_W'(n);
        cnt_wr_en = we; cnt_wr_data = CNT_W'(wd);
        irq_req = rq; irq_gie = ge;
        fire = cy & cm;
        #1;
        it.irq = ge & (|rq) & !((m_cnt != 0) | fire);
        it.act = (m_cnt != 0);
        it.cnt = CNT_W'(m_cnt);
        it.tag = tag;
        exp_q.push_back(it);
        @(posedge clk);
        if (fire)                  m_cnt = n;
        else if (cy && we)         m_cnt = wd;
        else if (cy && m_cnt != 0) m_cnt = m_cnt - 1;
    endtask

    task automatic run(input int k, input logic [NUM_IRQ-1:0] rq, input string tag);
        for (int i = 0; i < k; i++) step(1'b1, 1'b0, 0, 1'b0, 0, rq, 1'b1, tag);
    endtask

    // Monitor: compare the outputs away from the active edge
    initial begin
        forever begin
            @(negedge clk);
            #2;
            while (exp_q.size() != 0) begin
                item_t e;
                e = exp_q.pop_front();
                n_checks++;
                if (irq_out !== e.irq || hold_active !== e.act || hold_count !== e.cnt) begin
                    n_fail++;
                    $display("FAIL %s: irq/act/cnt actual %0b/%0b/%0d expected %0b/%0b/%0d",
                             e.tag, irq_out, hold_active, hold_count, e.irq, e.act, e.cnt);
                end
            end
        end
    end

    initial begin
        #4000000;
        if (!done) begin
            n_fail++;
            n_checks++;
            $display("FAIL watchdog: run did not finish");
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk) rst_n = 1'b1;

        // R1: reset state, requests pass
        step(1'b1, 1'b0, 0, 1'b0, 0, 8'h01, 1'b1, "R1 reset");
        // R9: plain forwarding with different request patterns
        step(1'b1, 1'b0, 0, 1'b0, 0, 8'h80, 1'b1, "R9 forward");
        step(1'b1, 1'b0, 0, 1'b0, 0, 8'h00, 1'b1, "R9 no request");
        step(1'b1, 1'b0, 0, 1'b0, 0, 8'hFF, 1'b0, "R9 gie low");

        // R2/R3: command N=3 masks four cycles then releases
        step(1'b1, 1'b1, 3, 1'b0, 0, 8'h04, 1'b1, "R2 command cycle");
        run(5, 8'h04, "R3 countdown");

        // R2: N=0 masks only the command cycle
        step(1'b1, 1'b1, 0, 1'b0, 0, 8'h10, 1'b1, "R2 zero operand");
        run(2, 8'h10, "R2 zero release");

        // R4: stalls mid-count, also ignoring command and write
        step(1'b1, 1'b1, 4, 1'b0, 0, 8'h02, 1'b1, "R4 arm");
        step(1'b1, 1'b0, 0, 1'b0, 0, 8'h02, 1'b1, "R4 tick");
        step(1'b0, 1'b0, 0, 1'b0, 0, 8'h02, 1'b1, "R4 stall");
        step(1'b0, 1'b1, 9, 1'b0, 0, 8'h02, 1'b1, "R4 stall cmd ignored");
        step(1'b0, 1'b0, 0, 1'b1, 7, 8'h02, 1'b1, "R4 stall write ignored");
        run(5, 8'h02, "R4 resume");

        // R5: re-arm while count above one
        step(1'b1, 1'b1, 3, 1'b0, 0, 8'h08, 1'b1, "R5 arm");
        run(1, 8'h08, "R5 tick");
        step(1'b1, 1'b1, 2, 1'b0, 0, 8'h08, 1'b1, "R5 rearm");
        run(4, 8'h08, "R5 after rearm");

        // R6: re-arm on the cycle the count is one
        step(1'b1, 1'b1, 2, 1'b0, 0, 8'h20, 1'b1, "R6 arm");
        run(1, 8'h20, "R6 tick");
        step(1'b1, 1'b1, 2, 1'b0, 0, 8'h20, 1'b1, "R6 rearm at one");
        run(4, 8'h20, "R6 after one");

        // R6: re-arm on the first cycle the count reads zero
        step(1'b1, 1'b1, 1, 1'b0, 0, 8'h40, 1'b1, "R6 arm2");
        run(1, 8'h40, "R6 tick2");
        step(1'b1, 1'b1, 3, 1'b0, 0, 8'h40, 1'b1, "R6 rearm at zero");
        run(5, 8'h40, "R6 after zero");

        // R7: direct write, then write of zero while counting
        step(1'b1, 1'b0, 0, 1'b1, 5, 8'h01, 1'b1, "R7 write five");
        run(2, 8'h01, "R7 count after write");
        step(1'b1, 1'b0, 0, 1'b1, 0, 8'h01, 1'b1, "R7 write zero");
        run(2, 8'h01, "R7 released");

        // R8: command beats write
        step(1'b1, 1'b1, 2, 1'b1, 9, 8'h01, 1'b1, "R8 cmd vs write");
        run(4, 8'h01, "R8 after");

        // R10: largest operand, then shorten by write
        step(1'b1, 1'b1, 16383, 1'b0, 0, 8'h03, 1'b1, "R10 max load");
        run(20, 8'h03, "R10 countdown");
        step(1'b1, 1'b0, 0, 1'b1, 1, 8'h03, 1'b1, "R10 shorten");
        run(3, 8'h03, "R10 release");

        @(negedge clk);
        #5;
        done = 1'b1;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

endmodule